// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block adds two 32-bit operands and a carry-in. The operand bits are cut into groups that widen toward the most significant end. The lowest group is a plain ripple-carry adder fed by the external carry-in. Every higher group does three things:

- It ripples its bits once, assuming a group carry-in of zero.
- It forms the alternative result by adding one to that partial result, carry-out included.
- A multiplexer, steered by the carry leaving the group below, picks one of the two.

The carry chain between groups therefore passes through one multiplexer per group, not through every bit.

A parameter swaps the incrementing stage for a second ripple adder with carry-in tied to one. This gives a reference variant with the same function. The sum and carry-out are captured in an output register with a synchronous active-high reset. A result appears one clock after its operands are presented.

Top module: `sqrt_csel_adder`

## Requirements
- R1: One clock edge after the operands `a_in`, `b_in` and `cin` are sampled with `rst` low, `{cout_q, sum_q}` equals the 33-bit value `a_in + b_in + cin`.
- R2: A clock edge with `rst` high clears `sum_q` and `cout_q` to zero.
- R3: From the least significant end, the groups are 2, 2, 3, 4, 5, 6, 7 and 3 bits wide, so group boundaries fall at bit positions 2, 4, 7, 11, 16, 22 and 29. A carry rippling across any of these boundaries gives the correct sum.
- R4: Each incrementing stage takes an (n+1)-bit input made of the group's carry-out above its n sum bits. Its output equals that input plus one, modulo 2^(n+1).
- R5: For each upper group, the selected sum and carry-out equal the group's operand slices added to its incoming carry.
- R6: The variant with two ripple adders per group (`DUAL_RCA` = 1) gives results identical to the default variant for every input.
- R7: The external carry-in enters the lowest group: zero operands with `cin` = 1 give a sum of 1 and a carry-out of 0.
- R8: All-ones operands wrap: `a_in` = `b_in` = 0xFFFFFFFF with `cin` = 1 gives a sum of 0xFFFFFFFF and a carry-out of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| cin | input | 1 | Carry into the least significant bit |
| sum_q | output | 32 | Registered sum |
| cout_q | output | 1 | Registered carry out of the most significant bit |

## Verification
The group and converter assertions assume that the operand inputs are settled two-state values while combinational logic is evaluated. For this reason they check nothing while any input is unknown. The output-register assertion assumes that the operands held one edge earlier are the ones that produced the stored result. The bench keeps to this by changing the inputs only at falling edges and reading the outputs a full cycle later. The directed patterns place carry chains that end exactly at every group boundary. The random vectors come from a fixed seed, so every run is identical.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int MAX_GROUPS = 64;

  function automatic int grp_raw(input int g);
    return (g == 0) ? 2 : g + 1;
  endfunction

  function automatic int grp_base(input int g);
    int b;
    b = 0;
    for (int k = 0; k < MAX_GROUPS; k++)
      if (k < g) b += grp_raw(k);
    return b;
  endfunction

  function automatic int grp_width(input int w, input int g);
    int r, left;
    r = grp_raw(g);
    left = w - grp_base(g);
    return (r < left) ? r : left;
  endfunction

  function automatic int num_groups(input int w);
    int n, b;
    n = 0;
    b = 0;
    for (int k = 0; k < MAX_GROUPS; k++)
      if (b < w) begin
        b += grp_raw(k);
        n++;
      end
    return n;
  endfunction
endpackage

// File: rtl/csel_rca.sv
module csel_rca #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         co
);
  logic [N:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign s[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign co = c[N];
endmodule

// File: rtl/csel_inc.sv
module csel_inc #(
  parameter int N = 3
) (
  input  logic [N-1:0] x,
  output logic [N-1:0] y
);
  logic [N-1:0] all_ones_below;
  assign all_ones_below[0] = 1'b1;

  for (genvar i = 1; i < N; i++) begin : g_chain
    assign all_ones_below[i] = all_ones_below[i-1] & x[i-1];
  end

  assign y = x ^ all_ones_below;

  always_comb begin
    if (!$isunknown(x))
      assert_inc_plus_one_R4: assert (y == x + N'(1))
        else $error("R4 increment stage: in=%0h out=%0h", x, y);
  end
endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int N        = 4,
  parameter bit DUAL_RCA = 1'b0
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sel,
  output logic [N-1:0] s,
  output logic         co
);
  logic [N-1:0] s0;
  logic         c0;
  logic [N:0]   alt;

  csel_rca #(.N(N)) u_rca0 (.a(a), .b(b), .ci(1'b0), .s(s0), .co(c0));

  if (DUAL_RCA) begin : g_dual
    logic [N-1:0] s1;
    logic         c1;
    csel_rca #(.N(N)) u_rca1 (.a(a), .b(b), .ci(1'b1), .s(s1), .co(c1));
    assign alt = {c1, s1};
  end else begin : g_inc
    csel_inc #(.N(N+1)) u_inc (.x({c0, s0}), .y(alt));
  end

  assign {co, s} = sel ? alt : {c0, s0};

  always_comb begin
    if (!$isunknown({a, b, sel}))
      assert_group_sum_R5: assert ({co, s} == ((N+1)'(a) + (N+1)'(b) + (N+1)'(sel)))
        else $error("R5 group: a=%0h b=%0h sel=%0b out=%0h", a, b, sel, {co, s});
  end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import csel_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter bit DUAL_RCA = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             cin,
  output logic [WIDTH-1:0] sum_q,
  output logic             cout_q
);
  localparam int NG = num_groups(WIDTH);

  logic [NG:0]      carry;
  logic [WIDTH-1:0] sum_c;

  assign carry[0] = cin;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int GB = grp_base(g);
    localparam int GW = grp_width(WIDTH, g);
    if (g == 0) begin : g_low
      csel_rca #(.N(GW)) u_rca (
        .a (a_in[GB +: GW]),
        .b (b_in[GB +: GW]),
        .ci(carry[g]),
        .s (sum_c[GB +: GW]),
        .co(carry[g+1])
      );
    end else begin : g_up
      csel_group #(.N(GW), .DUAL_RCA(DUAL_RCA)) u_grp (
        .a  (a_in[GB +: GW]),
        .b  (b_in[GB +: GW]),
        .sel(carry[g]),
        .s  (sum_c[GB +: GW]),
        .co (carry[g+1])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_c;
      cout_q <= carry[NG];
    end
  end

  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !cout_q));

  assert_sum_match_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout_q, sum_q} ==
      ((WIDTH+1)'($past(a_in)) + (WIDTH+1)'($past(b_in)) + (WIDTH+1)'($past(cin)))));
endmodule

// File: tb/sqrt_csel_adder_tb_top.sv
module sqrt_csel_adder_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic         ci = 1'b0;
  logic [W-1:0] sum_q, sum_r;
  logic         cout_q, cout_r;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sqrt_csel_adder #(.WIDTH(W), .DUAL_RCA(1'b0)) dut_i (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b), .cin(ci),
    .sum_q(sum_q), .cout_q(cout_q));

  sqrt_csel_adder #(.WIDTH(W), .DUAL_RCA(1'b1)) ref_i (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b), .cin(ci),
    .sum_q(sum_r), .cout_q(cout_r));

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic c);
    a = x; b = y; ci = c;
    @(posedge clk);
    @(negedge clk);
    check(req, {cout_q, sum_q}, model(x, y, c));
    check("R6", {cout_r, sum_r}, {cout_q, sum_q});
  endtask

  initial begin
    int seed;
    int bounds[7] = '{2, 4, 7, 11, 16, 22, 29};
    seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2", {cout_q, sum_q}, '0);
    rst = 1'b0;
    apply("R1", '0, '0, 1'b0);
    apply("R7", '0, '0, 1'b1);
    apply("R8", '1, '1, 1'b1);
    apply("R1", '1, '0, 1'b1);
    apply("R1", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    apply("R1", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    apply("R1", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1);
    for (int k = 0; k < 7; k++) begin
      logic [W-1:0] m;
      m = (32'h1 << bounds[k]) - 1;
      apply("R3", m, 32'h0, 1'b1);
      apply("R3", m, 32'h1, 1'b0);
      apply("R3", m >> 1, m >> 1, 1'b1);
    end
    for (int k = 0; k < 100000; k++)
      apply("R1", $urandom, $urandom, $urandom_range(1, 0) == 1);
    a = 32'hDEAD_BEEF;
    b = 32'h1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2", {cout_q, sum_q}, '0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule